// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block collects 72 level-sensitive interrupt lines and presents them to software through a small 32-bit register bus. Eight lines are local sources. The other 64 come from peripherals and are split into two banks of 32. In the global numbering, local sources take 0 to 7, bank one takes 8 to 39 and bank two takes 40 to 71. Each group has its own enable mask. Software sets mask bits through one register and clears them through another. A line counts as pending only while its input is high and its mask bit is set. Pending is never latched, so a line stops pending as soon as its source drops.

A summary register gathers the most useful information into one word. It holds the eight local pending bits and one "something pending" flag per bank. It also holds direct copies of eleven selected bank lines, which often lets a handler find the source without a second read. A single processor interrupt output is the registered OR of every enabled pending line.

The bus is a plain select/write/address/data port. Writes take effect on the clock edge. Read data is combinational from the address while the select is high.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every enable mask is zero. With every source held high, all pending and summary reads return 0 and the interrupt output stays low.
- R2: A write to an enable-set register sets the mask bits where the write data has a one and leaves the other bits unchanged. The registers are bank one at 0x10, bank two at 0x14 and local sources at 0x18; local uses data bits 7:0.
- R3: A write to a disable register clears the mask bits where the write data has a one and leaves the other bits unchanged. The registers are bank one at 0x1C, bank two at 0x20 and local sources at 0x24.
- R4: A read of any enable-set or disable register returns the current mask of that group. The local mask is zero-extended to 32 bits.
- R5: Offset 0x04 reads bank-one input AND mask, and offset 0x08 reads bank-two input AND mask. The value follows the input level, and a mask write is visible in the first read after the write edge.
- R6: In the summary register at 0x00, bits 7:0 are local input AND mask. Bit 8 is set when any enabled bank-one line is high, and bit 9 when any enabled bank-two line is high.
- R7: Summary bits 10 to 14 copy enabled bank-one lines 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 copy enabled bank-two lines 21, 22, 23, 24, 25 and 30, in that order. Bits 31:21 read zero.
- R8: The interrupt output equals, one clock later, the OR of all enabled pending lines in the three groups.
- R9: Reads of unmapped offsets (for example 0x0C, 0x28, 0x3C) return zero. Writes to the pending offsets or to unmapped offsets change no mask.
- R10: A bus cycle with the select low changes no mask, even with the write flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcBasic | input | 8 | Local interrupt lines |
| srcBank1 | input | 32 | Bank-one peripheral lines |
| srcBank2 | input | 32 | Bank-two peripheral lines |
| busSel | input | 1 | Bus select |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero when not selected |
| irqOut | output | 1 | Processor interrupt request |

## Verification
The masks are driven with random set and clear writes of random bit patterns to random groups, while random source levels are applied. A mask that only ever grows is therefore told apart from one that tracks both operations. Directed patterns raise a single shortcut line (bank-one line 9, then bank-two line 30). These expose wrong shortcut positions and wrong aggregate flags. Other directed cases write to read-only and unmapped offsets and drive the write flag with the select low. They show that only the six mask registers store anything. The reset case holds every source high with masks cleared, which tells raw-level reporting apart from enabled reporting.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned BASIC_N  = 8;
  localparam int unsigned BANK_N   = 32;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned SHORT1_N = 5;
  localparam int unsigned SHORT2_N = 6;
  localparam int unsigned AGG1_BIT = BASIC_N;
  localparam int unsigned AGG2_BIT = BASIC_N + 1;
  localparam int unsigned SHORT1_BASE = BASIC_N + 2;
  localparam int unsigned SHORT2_BASE = SHORT1_BASE + SHORT1_N;

  localparam int SHORT1_IDX [SHORT1_N] = '{7, 9, 10, 18, 19};
  localparam int SHORT2_IDX [SHORT2_N] = '{21, 22, 23, 24, 25, 30};

  localparam logic [ADDR_W-1:0] OFF_SUMMARY = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND1   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_PEND2   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_SET1    = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_SET2    = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_SETB    = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_CLR1    = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_CLR2    = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_CLRB    = 6'h24;

  typedef enum logic [2:0] {
    RD_NONE, RD_SUMMARY, RD_PEND1, RD_PEND2, RD_EN1, RD_EN2, RD_ENB
  } rdSel_e;

  typedef struct packed {
    logic   setBasic;
    logic   set1;
    logic   set2;
    logic   clrBasic;
    logic   clr1;
    logic   clr2;
    rdSel_e rdSel;
  } bicStrobe_t;
endpackage

// File: rtl/bic_ctrl.sv
module bic_ctrl
  import bic_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output bicStrobe_t        strobe
);
  logic wrEn;
  assign wrEn = busSel & busWrite;

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    if (busSel) begin
      unique case (busAddr)
        OFF_SUMMARY: strobe.rdSel = RD_SUMMARY;
        OFF_PEND1:   strobe.rdSel = RD_PEND1;
        OFF_PEND2:   strobe.rdSel = RD_PEND2;
        OFF_SET1: begin strobe.rdSel = RD_EN1; strobe.set1 = wrEn; end
        OFF_SET2: begin strobe.rdSel = RD_EN2; strobe.set2 = wrEn; end
        OFF_SETB: begin strobe.rdSel = RD_ENB; strobe.setBasic = wrEn; end
        OFF_CLR1: begin strobe.rdSel = RD_EN1; strobe.clr1 = wrEn; end
        OFF_CLR2: begin strobe.rdSel = RD_EN2; strobe.clr2 = wrEn; end
        OFF_CLRB: begin strobe.rdSel = RD_ENB; strobe.clrBasic = wrEn; end
        default:  strobe.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bic_enreg.sv
module bic_enreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         setStb,
  input  logic         clrStb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       mask <= '0;
    else if (setStb) mask <= mask | wdata;
    else if (clrStb) mask <= mask & ~wdata;
  end
endmodule

// File: rtl/bic_datapath.sv
module bic_datapath
  import bic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  bicStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [BASIC_N-1:0] srcBasic,
  input  logic [BANK_N-1:0]  srcBank1,
  input  logic [BANK_N-1:0]  srcBank2,
  output logic [DATA_W-1:0]  rdata,
  output logic               irqOut,
  output logic [BASIC_N-1:0] enBasic,
  output logic [BANK_N-1:0]  enBank1,
  output logic [BANK_N-1:0]  enBank2
);
  logic [BASIC_N-1:0] pendBasic;
  logic [BANK_N-1:0]  pend1, pend2;
  logic [DATA_W-1:0]  summary;

  bic_enreg #(.W(BASIC_N)) u_enB (
    .clk(clk), .rstN(rstN), .setStb(strobe.setBasic), .clrStb(strobe.clrBasic),
    .wdata(wdata[BASIC_N-1:0]), .mask(enBasic));
  bic_enreg #(.W(BANK_N)) u_en1 (
    .clk(clk), .rstN(rstN), .setStb(strobe.set1), .clrStb(strobe.clr1),
    .wdata(wdata[BANK_N-1:0]), .mask(enBank1));
  bic_enreg #(.W(BANK_N)) u_en2 (
    .clk(clk), .rstN(rstN), .setStb(strobe.set2), .clrStb(strobe.clr2),
    .wdata(wdata[BANK_N-1:0]), .mask(enBank2));

  assign pendBasic = srcBasic & enBasic;
  assign pend1     = srcBank1 & enBank1;
  assign pend2     = srcBank2 & enBank2;

  always_comb begin
    summary = '0;
    summary[BASIC_N-1:0] = pendBasic;
    summary[AGG1_BIT]    = |pend1;
    summary[AGG2_BIT]    = |pend2;
    for (int i = 0; i < SHORT1_N; i++) summary[SHORT1_BASE + i] = pend1[SHORT1_IDX[i]];
    for (int j = 0; j < SHORT2_N; j++) summary[SHORT2_BASE + j] = pend2[SHORT2_IDX[j]];
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_SUMMARY: rdata = summary;
      RD_PEND1:   rdata = DATA_W'(pend1);
      RD_PEND2:   rdata = DATA_W'(pend2);
      RD_EN1:     rdata = DATA_W'(enBank1);
      RD_EN2:     rdata = DATA_W'(enBank2);
      RD_ENB:     rdata = DATA_W'(enBasic);
      default:    rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= (|pendBasic) | (|pend1) | (|pend2);
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import bic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [BASIC_N-1:0] srcBasic,
  input  logic [BANK_N-1:0]  srcBank1,
  input  logic [BANK_N-1:0]  srcBank2,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);
  bicStrobe_t         strobe;
  logic [BASIC_N-1:0] enBasic;
  logic [BANK_N-1:0]  enBank1, enBank2;

  bic_ctrl u_ctrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .strobe(strobe));

  bic_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata),
    .srcBasic(srcBasic), .srcBank1(srcBank1), .srcBank2(srcBank2),
    .rdata(busRdata), .irqOut(irqOut),
    .enBasic(enBasic), .enBank1(enBank1), .enBank2(enBank2));
endmodule

// File: rtl/bic_checker.sv
module bic_checker
  import bic_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [BASIC_N-1:0] srcBasic,
  input logic [BANK_N-1:0]  srcBank1,
  input logic [BANK_N-1:0]  srcBank2,
  input logic               busSel,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic               irqOut,
  input logic [BASIC_N-1:0] enBasic,
  input logic [BANK_N-1:0]  enBank1,
  input logic [BANK_N-1:0]  enBank2
);
  // R2
  set_bank1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFF_SET1) |=>
      ((enBank1 & $past(busWdata)) == $past(busWdata)));

  // R3
  clr_bank2_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFF_CLR2) |=> ((enBank2 & $past(busWdata)) == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> ($stable(enBasic) && $stable(enBank1) && $stable(enBank2)));

  // R7
  summary_top_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAddr == OFF_SUMMARY) |-> (busRdata[DATA_W-1:SHORT2_BASE+SHORT2_N] == '0));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past((|(srcBasic & enBasic)) | (|(srcBank1 & enBank1)) |
                              (|(srcBank2 & enBank2)))));
endmodule

bind banked_irq_ctrl bic_checker u_chk (
  .clk(clk), .rstN(rstN), .srcBasic(srcBasic), .srcBank1(srcBank1),
  .srcBank2(srcBank2), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
  .enBasic(enBasic), .enBank1(enBank1), .enBank2(enBank2));

// File: tb/sim_banked_irq_ctrl.sv
`timescale 1ns/1ps
module sim_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  srcBasic = '0;
  logic [31:0] srcBank1 = '0, srcBank2 = '0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0]  mB = '0;
  logic [31:0] m1 = '0, m2 = '0;

  always #2 clk = ~clk;

  banked_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .srcBasic(srcBasic), .srcBank1(srcBank1),
    .srcBank2(srcBank2), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut));

  function automatic logic [31:0] expSummary();
    logic [31:0] s = '0;
    logic [31:0] p1 = srcBank1 & m1;
    logic [31:0] p2 = srcBank2 & m2;
    s[7:0] = srcBasic & mB;
    s[8] = |p1;
    s[9] = |p2;
    s[10] = p1[7]; s[11] = p1[9]; s[12] = p1[10]; s[13] = p1[18]; s[14] = p1[19];
    s[15] = p2[21]; s[16] = p2[22]; s[17] = p2[23]; s[18] = p2[24]; s[19] = p2[25];
    s[20] = p2[30];
    return s;
  endfunction

  function automatic logic expIrq();
    return (|(srcBasic & mB)) | (|(srcBank1 & m1)) | (|(srcBank2 & m2));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input bit sel = 1'b1);
    @(negedge clk);
    busSel = sel; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    if (sel) begin
      case (a)
        6'h10: m1 = m1 | d;
        6'h14: m2 = m2 | d;
        6'h18: mB = mB | d[7:0];
        6'h1C: m1 = m1 & ~d;
        6'h20: m2 = m2 & ~d;
        6'h24: mB = mB & ~d[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] d;
    rd(6'h00, d); chk({tag, " R6 R7 summary"}, d, expSummary());
    rd(6'h04, d); chk({tag, " R5 pend1"}, d, srcBank1 & m1);
    rd(6'h08, d); chk({tag, " R5 pend2"}, d, srcBank2 & m2);
    rd(6'h10, d); chk({tag, " R4 en1"}, d, m1);
    rd(6'h20, d); chk({tag, " R4 en2"}, d, m2);
    rd(6'h24, d); chk({tag, " R4 enB"}, d, {24'h0, mB});
    chk({tag, " R8 irq"}, {31'h0, irqOut}, {31'h0, expIrq()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: all sources high, masks cleared
    srcBasic = '1; srcBank1 = '1; srcBank2 = '1;
    @(negedge clk); @(negedge clk);
    rd(6'h00, d); chk("R1 summary", d, 32'h0);
    rd(6'h04, d); chk("R1 pend1", d, 32'h0);
    rd(6'h08, d); chk("R1 pend2", d, 32'h0);
    rd(6'h18, d); chk("R1 enB", d, 32'h0);
    chk("R1 irq", {31'h0, irqOut}, 32'h0);

    // R2 / R5: enable visible next read
    wr(6'h10, 32'h0000_0200);
    rd(6'h04, d); chk("R5 pend1 after enable", d, 32'h0000_0200);
    rd(6'h1C, d); chk("R2 en1", d, 32'h0000_0200);
    wr(6'h10, 32'h8000_0001);
    rd(6'h10, d); chk("R2 en1 accumulate", d, 32'h8000_0201);
    // R3
    wr(6'h1C, 32'h0000_0201);
    rd(6'h10, d); chk("R3 en1 clear", d, 32'h8000_0000);

    // R7 directed shortcut: bank1 line 9 only
    wr(6'h10, 32'hFFFF_FFFF);
    srcBasic = '0; srcBank1 = 32'h0000_0200; srcBank2 = '0;
    @(negedge clk);
    rd(6'h00, d); chk("R7 shortcut b1 line9", d, 32'h0000_0900);
    // bank2 line 30 only
    wr(6'h14, 32'hFFFF_FFFF);
    srcBank1 = '0; srcBank2 = 32'h4000_0000;
    @(negedge clk);
    rd(6'h00, d); chk("R7 shortcut b2 line30", d, 32'h0010_0200);
    chk("R8 irq from bank2", {31'h0, irqOut}, 32'h1);
    srcBank2 = '0;
    @(negedge clk); @(negedge clk);
    chk("R8 irq drops", {31'h0, irqOut}, 32'h0);
    rd(6'h08, d); chk("R5 pend2 follows level", d, 32'h0);

    // R9 unmapped reads and read-only writes
    rd(6'h0C, d); chk("R9 read 0x0C", d, 32'h0);
    rd(6'h28, d); chk("R9 read 0x28", d, 32'h0);
    rd(6'h3C, d); chk("R9 read 0x3C", d, 32'h0);
    wr(6'h04, 32'h0);  wr(6'h0C, 32'hFFFF_FFFF); wr(6'h28, 32'hFFFF_FFFF);
    wr(6'h00, 32'hFFFF_FFFF); wr(6'h08, 32'h0);
    rd(6'h10, d); chk("R9 en1 unchanged", d, m1);
    rd(6'h14, d); chk("R9 en2 unchanged", d, m2);
    rd(6'h18, d); chk("R9 enB unchanged", d, {24'h0, mB});

    // R10 select low
    wr(6'h1C, 32'hFFFF_FFFF, 1'b0);
    wr(6'h18, 32'h0000_00FF, 1'b0);
    rd(6'h10, d); chk("R10 en1 held", d, 32'hFFFF_FFFF);
    rd(6'h18, d); chk("R10 enB held", d, 32'h0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [5:0] a;
      logic [31:0] v;
      case ($urandom_range(0, 5))
        0: a = 6'h10; 1: a = 6'h14; 2: a = 6'h18;
        3: a = 6'h1C; 4: a = 6'h20; default: a = 6'h24;
      endcase
      v = $urandom() & $urandom();
      wr(a, v);
      srcBasic = 8'($urandom());
      srcBank1 = $urandom() & $urandom();
      srcBank2 = $urandom() & $urandom();
      @(negedge clk);
      checkAll("rand");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule